// File: doc/BRIEF.md
# SPI Interrupt Status Register

This block keeps the event flags of an SPI controller and turns them into one interrupt line. The transfer engine pulses a strobe at the end of each element transfer, together with an under-run request flag and the level of the transmit FIFO's empty signal. A slave-select monitor supplies the select level, and the configuration supplies master/slave mode and an enable. Four event bits sit at the top of a status word. Software reads that word over a simple one-address-bit register bus. Writing a one to a bit inverts it, and writing a zero leaves it alone. A second register holds a per-bit enable mask for the interrupt.

Two parameters pick the variant. `HAS_FIFO` makes the transmit-empty event follow the FIFO level instead of firing on every element. `MASTER_ONLY` ties the three bits that cannot occur in a master-only build to zero. While the transmit-empty bit is set in master mode, the block raises a transfer-inhibit output so the engine starts no further element.

Top module: `spi_irq_status`

## Requirements
- R1: After a synchronous active-low reset, all status bits, the enable mask and `irq_o` are 0.
- R2: `bus_addr_i`=0 selects the status word and `bus_addr_i`=1 selects the enable mask, both for reads on `bus_rdata_o`. A write to address 1 loads the mask. A write to address 0 inverts every event bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged.
- R3: Status bit 28 (under-run) is set in the cycle after a strobe on `elem_done_i` while `underrun_req_i` is 1.
- R4: Status bit 29 (transmit empty) is set in the cycle after an `elem_done_i` strobe. With `HAS_FIFO`=1, this happens only when `tx_fifo_empty_i` is 1 with the strobe. With `HAS_FIFO`=0, it happens on every strobe.
- R5: `xfer_inhibit_o` is 1 exactly when status bit 29 is 1 and the block is in master mode. Master mode means `cfg_master_i`=1, or the block is built with `MASTER_ONLY`=1.
- R6: Status bit 31 (mode fault) is set in the cycle after `ss_active_i` goes from 0 to 1 while `cfg_master_i`=1. The first cycle after reset counts as a rise.
- R7: Status bit 30 (slave mode fault) is set after every cycle in which `ss_active_i`=1, `cfg_master_i`=0 and `cfg_enable_i`=0. A toggle write cannot clear it while that condition holds.
- R8: Status bits 27..0 always read 0. With `MASTER_ONLY`=1, bits 28, 30 and 31 stay 0 whatever the inputs and writes are.
- R9: When a hardware set event and a toggle write reach the same bit in the same cycle, the bit ends up at 1.
- R10: `irq_o` is the OR over all bits of (status AND mask), registered. It therefore follows the status and mask one cycle late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| elem_done_i | input | 1 | One-cycle strobe at the end of an element transfer |
| underrun_req_i | input | 1 | Data was requested from an empty transmit store during this element |
| tx_fifo_empty_i | input | 1 | Transmit FIFO empty level |
| ss_active_i | input | 1 | Slave-select active level |
| cfg_master_i | input | 1 | 1 selects master mode |
| cfg_enable_i | input | 1 | Device enable |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | 0 selects the status word, 1 selects the enable mask |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data of the selected register |
| status_o | output | DATA_W | Status word |
| irq_o | output | 1 | Registered masked interrupt |
| xfer_inhibit_o | output | 1 | Master-mode transfer inhibit |

## Verification
The bench builds two instances side by side on the same stimulus. The first uses `HAS_FIFO`=1 and `MASTER_ONLY`=0. In this build the FIFO-gated empty event can be tested, along with both mode-fault bits, the under-run bit and the mode-dependent inhibit. The second uses `HAS_FIFO`=0 and `MASTER_ONLY`=1. It covers the empty event on every element and the tied bits, including toggle writes aimed at those tied bits, and it shows the inhibit firing without `cfg_master_i`.

// File: rtl/spi_irq_pkg.sv
// Shared constants for the SPI interrupt status block.
// Assumes the event field sits in the top NUM_EV bits of the status word.
package spi_irq_pkg;
    localparam int NUM_EV = 4;

    // Index of each event inside the event field (LSB of field = index 0)
    typedef enum int {
        EV_UNDERRUN  = 0,
        EV_TXEMPTY   = 1,
        EV_SLVFAULT  = 2,
        EV_MODEFAULT = 3
    } ev_idx_e;

    localparam logic ADDR_STATUS = 1'b0;
    localparam logic ADDR_MASK   = 1'b1;
endpackage

// File: rtl/spi_irq_event_detect.sv
// Turns engine strobes and the slave-select level into per-event set pulses.
// Assumes elem_done_i is a single-cycle strobe. The master-only and FIFO
// variants are chosen at elaboration time.
module spi_irq_event_detect
    import spi_irq_pkg::*;
#(
    parameter bit HAS_FIFO    = 1'b1,
    parameter bit MASTER_ONLY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              elem_done_i,
    input  logic              underrun_req_i,
    input  logic              tx_fifo_empty_i,
    input  logic              ss_active_i,
    input  logic              cfg_master_i,
    input  logic              cfg_enable_i,
    output logic [NUM_EV-1:0] set_o
);
    logic ss_prev_q;

    // Remember the last select level so that a rise can be detected
    always_ff @(posedge clk) begin
        if (!rst_n) ss_prev_q <= 1'b0;
        else        ss_prev_q <= ss_active_i;
    end

    generate
        if (HAS_FIFO) begin : g_fifo
            // Empty event only when the element drained the FIFO
            always_comb set_o[EV_TXEMPTY] = elem_done_i & tx_fifo_empty_i;
        end else begin : g_nofifo
            // Empty event at the end of every element
            always_comb set_o[EV_TXEMPTY] = elem_done_i;
        end

        if (MASTER_ONLY) begin : g_mo
            // Faults and under-run cannot occur in a master-only build
            always_comb begin
                set_o[EV_UNDERRUN]  = 1'b0;
                set_o[EV_SLVFAULT]  = 1'b0;
                set_o[EV_MODEFAULT] = 1'b0;
            end
        end else begin : g_full
            // Under-run on element end, slave fault as a level, mode fault on rise
            always_comb begin
                set_o[EV_UNDERRUN]  = elem_done_i & underrun_req_i;
                set_o[EV_SLVFAULT]  = ss_active_i & ~cfg_master_i & ~cfg_enable_i;
                set_o[EV_MODEFAULT] = ss_active_i & ~ss_prev_q & cfg_master_i;
            end
        end
    endgenerate
endmodule

// File: rtl/spi_irq_tow_reg.sv
// A row of toggle-on-write flag bits. A set pulse wins over a toggle in
// the same cycle, so no hardware event is lost.
module spi_irq_tow_reg #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] tog_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // One flag: reset, then set priority, then toggle
        always_ff @(posedge clk) begin
            if (!rst_n)        q_o[i] <= 1'b0;
            else if (set_i[i]) q_o[i] <= 1'b1;
            else if (tog_i[i]) q_o[i] <= ~q_o[i];
        end
    end
endmodule

// File: rtl/spi_irq_status.sv
// Interrupt status register of an SPI controller. It holds the event flags
// in the top bits of the status word, a plain enable mask, a registered
// masked interrupt and a master-mode transfer inhibit.
// Assumes a one-bit address: 0 = status (toggle on write), 1 = mask.
module spi_irq_status
    import spi_irq_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter bit HAS_FIFO    = 1'b1,
    parameter bit MASTER_ONLY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              elem_done_i,
    input  logic              underrun_req_i,
    input  logic              tx_fifo_empty_i,
    input  logic              ss_active_i,
    input  logic              cfg_master_i,
    input  logic              cfg_enable_i,
    input  logic              bus_wr_i,
    input  logic              bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic [DATA_W-1:0] status_o,
    output logic              irq_o,
    output logic              xfer_inhibit_o
);
    localparam int RSV_W = DATA_W - NUM_EV;
    localparam logic [NUM_EV-1:0] LIVE = MASTER_ONLY ? (NUM_EV'(1) << EV_TXEMPTY)
                                                     : {NUM_EV{1'b1}};

    logic [NUM_EV-1:0] set_v;
    logic [NUM_EV-1:0] tog_v;
    logic [NUM_EV-1:0] ev_q;
    logic [DATA_W-1:0] mask_q;
    logic              irq_q;

    spi_irq_event_detect #(
        .HAS_FIFO   (HAS_FIFO),
        .MASTER_ONLY(MASTER_ONLY)
    ) u_detect (
        .clk            (clk),
        .rst_n          (rst_n),
        .elem_done_i    (elem_done_i),
        .underrun_req_i (underrun_req_i),
        .tx_fifo_empty_i(tx_fifo_empty_i),
        .ss_active_i    (ss_active_i),
        .cfg_master_i   (cfg_master_i),
        .cfg_enable_i   (cfg_enable_i),
        .set_o          (set_v)
    );

    // Toggle request from a status write, limited to bits this build keeps
    always_comb begin
        tog_v = '0;
        if (bus_wr_i && bus_addr_i == ADDR_STATUS)
            tog_v = bus_wdata_i[DATA_W-1 -: NUM_EV] & LIVE;
    end

    spi_irq_tow_reg #(.N(NUM_EV)) u_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(set_v),
        .tog_i(tog_v),
        .q_o  (ev_q)
    );

    // Enable mask: plain load on a mask write
    always_ff @(posedge clk) begin
        if (!rst_n)                                     mask_q <= '0;
        else if (bus_wr_i && bus_addr_i == ADDR_MASK)   mask_q <= bus_wdata_i;
    end

    // Assemble the status word with the reserved bits held at zero
    always_comb status_o = {ev_q, {RSV_W{1'b0}}};

    // Registered interrupt from the masked status
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(status_o & mask_q);
    end

    // Read mux and outputs
    always_comb begin
        bus_rdata_o    = (bus_addr_i == ADDR_MASK) ? mask_q : status_o;
        irq_o          = irq_q;
        xfer_inhibit_o = ev_q[EV_TXEMPTY] & (MASTER_ONLY | cfg_master_i);
    end
endmodule

// File: rtl/spi_irq_status_chk.sv
// Property checker for spi_irq_status, attached with bind below.
// Observes ports plus the enable mask register.
module spi_irq_status_chk
    import spi_irq_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter bit HAS_FIFO    = 1'b1,
    parameter bit MASTER_ONLY = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              elem_done_i,
    input logic              tx_fifo_empty_i,
    input logic              ss_active_i,
    input logic              cfg_master_i,
    input logic              cfg_enable_i,
    input logic              bus_wr_i,
    input logic              bus_addr_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic [DATA_W-1:0] status_o,
    input logic [DATA_W-1:0] mask_q,
    input logic              irq_o,
    input logic              xfer_inhibit_o
);
    localparam int RSV_W = DATA_W - NUM_EV;
    localparam int B_UR  = RSV_W + EV_UNDERRUN;
    localparam int B_TE  = RSV_W + EV_TXEMPTY;
    localparam int B_SF  = RSV_W + EV_SLVFAULT;
    localparam int B_MF  = RSV_W + EV_MODEFAULT;

    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[RSV_W-1:0] == '0);

    a_r8_tied_bits: assert property (@(posedge clk) disable iff (!rst_n)
        MASTER_ONLY |-> (!status_o[B_UR] && !status_o[B_SF] && !status_o[B_MF]));

    a_r4_empty_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_done_i && (!HAS_FIFO || tx_fifo_empty_i)) |=> status_o[B_TE]);

    a_r7_slave_fault_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!MASTER_ONLY && ss_active_i && !cfg_master_i && !cfg_enable_i) |=> status_o[B_SF]);

    a_r6_mode_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (!MASTER_ONLY && ss_active_i && !$past(ss_active_i) && cfg_master_i) |=> status_o[B_MF]);

    a_r5_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[B_TE] && (cfg_master_i || MASTER_ONLY)) |-> xfer_inhibit_o);

    a_r2_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == ADDR_STATUS && !bus_wdata_i[B_TE] && !elem_done_i)
        |=> $stable(status_o[B_TE]));

    a_r10_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(status_o & mask_q))));
endmodule

bind spi_irq_status spi_irq_status_chk #(
    .DATA_W     (DATA_W),
    .HAS_FIFO   (HAS_FIFO),
    .MASTER_ONLY(MASTER_ONLY)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .elem_done_i    (elem_done_i),
    .tx_fifo_empty_i(tx_fifo_empty_i),
    .ss_active_i    (ss_active_i),
    .cfg_master_i   (cfg_master_i),
    .cfg_enable_i   (cfg_enable_i),
    .bus_wr_i       (bus_wr_i),
    .bus_addr_i     (bus_addr_i),
    .bus_wdata_i    (bus_wdata_i),
    .status_o       (status_o),
    .mask_q         (mask_q),
    .irq_o          (irq_o),
    .xfer_inhibit_o (xfer_inhibit_o)
);

// File: tb/spi_irq_status_bench.sv
`timescale 1ns/1ps
// Bench: two builds (FIFO + full, no-FIFO + master-only) against a
// behavioural model compared on every falling edge, plus directed checks.
module spi_irq_status_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        done = 0, urq = 0, fempty = 0, ss = 0, master = 0, en = 0;
    logic        wr = 0, addr = 0;
    logic [31:0] wdata = '0;

    logic [31:0] rd0, st0, rd1, st1;
    logic        irq0, inh0, irq1, inh1;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    spi_irq_status #(.DATA_W(32), .HAS_FIFO(1'b1), .MASTER_ONLY(1'b0)) u_spi_irq_status (
        .clk(clk), .rst_n(rst_n), .elem_done_i(done), .underrun_req_i(urq),
        .tx_fifo_empty_i(fempty), .ss_active_i(ss), .cfg_master_i(master),
        .cfg_enable_i(en), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rd0), .status_o(st0), .irq_o(irq0), .xfer_inhibit_o(inh0));

    spi_irq_status #(.DATA_W(32), .HAS_FIFO(1'b0), .MASTER_ONLY(1'b1)) u_spi_irq_status_mo (
        .clk(clk), .rst_n(rst_n), .elem_done_i(done), .underrun_req_i(urq),
        .tx_fifo_empty_i(fempty), .ss_active_i(ss), .cfg_master_i(master),
        .cfg_enable_i(en), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rd1), .status_o(st1), .irq_o(irq1), .xfer_inhibit_o(inh1));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model: index 0 = FIFO/full build, 1 = no-FIFO/master-only
    logic [3:0]  m_ev   [2];
    logic [31:0] m_mask [2];
    logic        m_irq  [2];
    logic        m_ssprev;

    always @(posedge clk) begin
        for (int c = 0; c < 2; c++) begin
            logic [3:0] live, setv, tog;
            if (!rst_n) begin
                m_ev[c] = '0; m_mask[c] = '0; m_irq[c] = 1'b0;
            end else begin
                live = (c == 1) ? 4'b0010 : 4'b1111;
                setv[0] = done & urq;
                setv[1] = (c == 0) ? (done & fempty) : done;
                setv[2] = ss & !master & !en;
                setv[3] = ss & !m_ssprev & master;
                setv = setv & live;
                tog = (wr && addr == 1'b0) ? (wdata[31:28] & live) : 4'b0;
                m_irq[c] = |({m_ev[c], 28'b0} & m_mask[c]);
                m_ev[c] = setv | (m_ev[c] ^ tog);
                if (wr && addr == 1'b1) m_mask[c] = wdata;
            end
        end
        m_ssprev = rst_n ? ss : 1'b0;
    end

    string tags[4] = '{"R3", "R4", "R7", "R6"};

    task automatic cmp_one(input int c, input logic [31:0] st, input logic [31:0] rd,
                           input logic irq, input logic inh);
        logic [31:0] exp_st;
        logic        exp_inh;
        exp_st = {m_ev[c], 28'b0};
        for (int b = 0; b < 4; b++)
            chk((c == 1 && b != 1) ? "R8" : tags[b], 32'(st[28+b]), 32'(exp_st[28+b]));
        chk("R8", {4'b0, st[27:0]}, 32'b0);
        chk("R2", rd, addr ? m_mask[c] : exp_st);
        chk("R10", 32'(irq), 32'(m_irq[c]));
        exp_inh = m_ev[c][1] & ((c == 1) | master);
        chk("R5", 32'(inh), 32'(exp_inh));
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            cmp_one(0, st0, rd0, irq0, inh0);
            cmp_one(1, st1, rd1, irq1, inh1);
        end
    end

    task automatic tick();
        @(posedge clk); #1;
        done = 0; wr = 0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset values of status, mask (read via address 1) and irq
        chk("R1", st0, 32'b0); chk("R1", st1, 32'b0);
        chk("R1", 32'(irq0), 32'b0);
        addr = 1; #0.5; chk("R1", rd0, 32'b0); addr = 0;
        rst_n = 1;
        tick();

        // R2: load the mask with all ones
        wr = 1; addr = 1; wdata = 32'hFFFF_FFFF; tick();
        chk("R2", rd0, 32'hFFFF_FFFF);
        addr = 0;

        // R4: element end without FIFO empty: only the no-FIFO build sets
        done = 1; fempty = 0; tick();
        chk("R4", 32'(st0[29]), 32'b0); chk("R4", 32'(st1[29]), 32'b1);
        chk("R5", 32'(inh1), 32'b1);  // master-only inhibits without cfg_master
        tick();
        chk("R10", 32'(irq1), 32'b1);

        // R4: element end with FIFO empty sets the FIFO build
        done = 1; fempty = 1; tick();
        chk("R4", 32'(st0[29]), 32'b1);
        chk("R5", 32'(inh0), 32'b0);  // slave mode: no inhibit
        master = 1; #0.5; chk("R5", 32'(inh0), 32'b1);

        // R2: toggle bit 29 off in both, zero bits leave others
        wr = 1; wdata = 32'h2000_0000; tick();
        chk("R2", 32'(st0[29]), 32'b0); chk("R2", 32'(st1[29]), 32'b0);

        // R6: select rise in master mode
        ss = 1; tick();
        chk("R6", 32'(st0[31]), 32'b1); chk("R8", 32'(st1[31]), 32'b0);
        ss = 0; tick();
        wr = 1; wdata = 32'h8000_0000; tick();
        chk("R2", 32'(st0[31]), 32'b0);

        // R7: slave not enabled, select held; toggle cannot clear it
        master = 0; en = 0; ss = 1; tick();
        chk("R7", 32'(st0[30]), 32'b1);
        wr = 1; wdata = 32'h4000_0000; tick();
        chk("R7", 32'(st0[30]), 32'b1);
        ss = 0; tick();
        wr = 1; wdata = 32'h4000_0000; tick();
        chk("R7", 32'(st0[30]), 32'b0);

        // R8: toggle writes aimed at tied bits of the master-only build
        wr = 1; wdata = 32'hFFFF_FFFF; tick();
        chk("R8", st1 & 32'hDFFF_FFFF, 32'b0);
        chk("R8", 32'(st1[29]), 32'b1);

        // R9: set and toggle on the same bit in the same cycle -> 1
        done = 1; fempty = 1; wr = 1; wdata = 32'h2000_0000; tick();
        chk("R9", 32'(st0[29]), 32'b1); chk("R9", 32'(st1[29]), 32'b1);

        // R3: under-run on an element end
        done = 1; urq = 1; tick();
        urq = 0;
        chk("R3", 32'(st0[28]), 32'b1); chk("R8", 32'(st1[28]), 32'b0);

        // Pseudo-random phase against the model
        lfsr = 32'h1ACE_B00C;
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            done   = lfsr[3] & lfsr[7];
            urq    = lfsr[9];
            fempty = lfsr[11];
            if (lfsr[15:13] == 3'b0) ss = ~ss;
            if (lfsr[20:17] == 4'b0) master = ~master;
            if (lfsr[24:21] == 4'b0) en = ~en;
            wr     = lfsr[25] & lfsr[26];
            addr   = lfsr[27] & lfsr[28] & lfsr[29];
            wdata  = {lfsr[31:28] ^ lfsr[3:0], lfsr[27:0]};
            if (i == 2000) rst_n = 0;
            if (i == 2003) rst_n = 1;
            tick();
        end
        tick();
        finish_run();
    end
endmodule